// File: doc/BRIEF.md
# Chip-Select Gated Command/Address Register

This block is the command/address register of a memory module. On each rising clock edge it captures a 22-bit gated data word, two active-low chip-select bits, and four ungated control bits (two clock-enable and two on-die-termination). Every registered bit drives two identical output copies, A and B, so that two groups of memory devices can be fed from one register.

A gate-enable input decides how the gated data word updates. With gate-enable low, the data word is captured on every edge. With gate-enable high, the data word is captured only on an edge where at least one chip select is low. When both chip selects are high, the data outputs keep their previous value. Chip-select, clock-enable and termination bits are never gated and follow their inputs one edge later.

An active-low reset acts asynchronously and clears every register. It overrides the gating. After reset is released the outputs stay low until an edge loads new values.

Top module: `cabuf_ca_register`

## Requirements
- R1: While `rst_n` is low, every output is 0. Asserting `rst_n` clears the outputs at once, without waiting for a clock edge.
- R2: With `gate_en` = 0, `dat_a`/`dat_b` show, after each rising edge, the `dat_in` value sampled at that edge, whatever `cs_n_in` holds.
- R3: With `gate_en` = 1 and at least one bit of `cs_n_in` equal to 0 (patterns 2'b00, 2'b01, 2'b10), `dat_in` is captured at the edge and appears on `dat_a`/`dat_b`.
- R4: With `gate_en` = 1 and `cs_n_in` = 2'b11 at an edge, `dat_a`/`dat_b` keep their previous value, whatever `dat_in` holds.
- R5: `cke_a`/`cke_b` and `odt_a`/`odt_b` take the `cke_in` and `odt_in` values sampled at every rising edge, whatever `gate_en` and `cs_n_in` hold.
- R6: `cs_n_a`/`cs_n_b` take the `cs_n_in` value sampled at every rising edge. Bit 0 is chip select 0 and bit 1 is chip select 1. They are not gated.
- R7: The A copy and the B copy of each output group are always equal.
- R8: After `rst_n` rises, every output stays 0 until the next rising edge. If that edge has `gate_en` = 1 and `cs_n_in` = 2'b11, the data outputs stay 0 past it.
- R9: Clock edges that occur while `rst_n` is low load nothing. The outputs stay 0 for any input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | 1: data word updates only when a chip select is low |
| cs_n_in | input | 2 | Active-low chip selects, bit 0 = select 0 |
| dat_in | input | 22 | Chip-select gated data word |
| cke_in | input | 2 | Clock-enable bits, ungated |
| odt_in | input | 2 | Termination-control bits, ungated |
| dat_a | output | 22 | Registered data word, copy A |
| dat_b | output | 22 | Registered data word, copy B |
| cs_n_a | output | 2 | Registered chip selects, copy A |
| cs_n_b | output | 2 | Registered chip selects, copy B |
| cke_a | output | 2 | Registered clock enables, copy A |
| cke_b | output | 2 | Registered clock enables, copy B |
| odt_a | output | 2 | Registered termination bits, copy A |
| odt_b | output | 2 | Registered termination bits, copy B |

## Verification
The clocked properties take for granted that `gate_en`, `cs_n_in`, the data inputs and `rst_n` never change at a rising clock edge. They also assume that an edge-to-edge comparison is meaningful only when reset was high at the earlier edge, so every comparison is disabled while reset is low. The stimulus honours this: it changes inputs only at falling edges. It releases reset at a falling edge and asserts it in the middle of a cycle, so the reset properties see the asynchronous clear separately from any capture.

// File: rtl/cabuf_pkg.sv
package cabuf_pkg;

    localparam int DAT_W  = 22;
    localparam int CS_W   = 2;
    localparam int CKE_W  = 2;
    localparam int ODT_W  = 2;
    localparam int COPIES = 2;
    localparam int CTL_W  = CS_W + CKE_W + ODT_W;

    typedef struct packed {
        logic [CS_W-1:0]  cs_n;
        logic [CKE_W-1:0] cke;
        logic [ODT_W-1:0] odt;
    } ctl_word_t;

    typedef enum logic [1:0] {
        CAP_EVERY_EDGE = 2'd0,
        CAP_SELECTED   = 2'd1,
        CAP_BLOCKED    = 2'd2
    } cap_mode_t;

    // Capture policy for the gated data word.
    function automatic cap_mode_t data_cap_mode(input logic gate_en,
                                                input logic [CS_W-1:0] cs_n);
        if (!gate_en)
            return CAP_EVERY_EDGE;
        else if (&cs_n)
            return CAP_BLOCKED;
        else
            return CAP_SELECTED;
    endfunction

endpackage

// File: rtl/cabuf_gate_ctl.sv
module cabuf_gate_ctl
    import cabuf_pkg::*;
#(
    parameter int SEL_W = CS_W
) (
    input  logic             gate_en,
    input  logic [SEL_W-1:0] cs_n,
    output cap_mode_t        mode,
    output logic             load
);

    always_comb begin
        mode = data_cap_mode(gate_en, cs_n);
        load = (mode != CAP_BLOCKED);
    end

endmodule

// File: rtl/cabuf_reg_bank.sv
module cabuf_reg_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));  // R3
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));  // R4

endmodule

// File: rtl/cabuf_fanout.sv
module cabuf_fanout #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic                 [W-1:0] src,
    output logic [N-1:0]         [W-1:0] dst
);

    for (genvar k = 0; k < N; k++) begin : g_copy
        assign dst[k] = src;
    end

endmodule

// File: rtl/cabuf_ca_register.sv
module cabuf_ca_register
    import cabuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_en,
    input  logic [CS_W-1:0]  cs_n_in,
    input  logic [DAT_W-1:0] dat_in,
    input  logic [CKE_W-1:0] cke_in,
    input  logic [ODT_W-1:0] odt_in,
    output logic [DAT_W-1:0] dat_a,
    output logic [DAT_W-1:0] dat_b,
    output logic [CS_W-1:0]  cs_n_a,
    output logic [CS_W-1:0]  cs_n_b,
    output logic [CKE_W-1:0] cke_a,
    output logic [CKE_W-1:0] cke_b,
    output logic [ODT_W-1:0] odt_a,
    output logic [ODT_W-1:0] odt_b
);

    cap_mode_t  mode;
    logic       dat_load;
    logic [DAT_W-1:0] dat_q;
    ctl_word_t  ctl_d, ctl_q;
    logic [COPIES-1:0][DAT_W-1:0] dat_fan;
    logic [COPIES-1:0][CTL_W-1:0] ctl_fan;
    ctl_word_t  ctl_a, ctl_b;

    cabuf_gate_ctl #(.SEL_W(CS_W)) u_gate (
        .gate_en (gate_en),
        .cs_n    (cs_n_in),
        .mode    (mode),
        .load    (dat_load)
    );

    cabuf_reg_bank #(.W(DAT_W)) u_dat_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dat_load),
        .d     (dat_in),
        .q     (dat_q)
    );

    assign ctl_d = '{cs_n: cs_n_in, cke: cke_in, odt: odt_in};

    cabuf_reg_bank #(.W(CTL_W)) u_ctl_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (1'b1),
        .d     (ctl_d),
        .q     (ctl_q)
    );

    cabuf_fanout #(.W(DAT_W), .N(COPIES)) u_dat_fan (
        .src (dat_q),
        .dst (dat_fan)
    );

    cabuf_fanout #(.W(CTL_W), .N(COPIES)) u_ctl_fan (
        .src (ctl_q),
        .dst (ctl_fan)
    );

    assign ctl_a  = ctl_word_t'(ctl_fan[0]);
    assign ctl_b  = ctl_word_t'(ctl_fan[1]);
    assign dat_a  = dat_fan[0];
    assign dat_b  = dat_fan[1];
    assign cs_n_a = ctl_a.cs_n;
    assign cs_n_b = ctl_b.cs_n;
    assign cke_a  = ctl_a.cke;
    assign cke_b  = ctl_b.cke;
    assign odt_a  = ctl_a.odt;
    assign odt_b  = ctl_b.odt;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (dat_a == '0 && cs_n_a == '0 && cke_a == '0 && odt_a == '0)); // R1
    AST_OPEN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> (dat_a == $past(dat_in)));  // R2
    AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && (&cs_n_in)) |=> $stable(dat_b));  // R4
    AST_CTRL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cke_b == $past(cke_in) && odt_b == $past(odt_in)));  // R5
    AST_CS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cs_n_b == $past(cs_n_in)));  // R6

endmodule

// File: tb/tb_cabuf_ca_register.sv
`timescale 1ns/1ps
module tb_cabuf_ca_register;

    localparam int DW = 22;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          gate_en;
    logic [1:0]    cs_n_in;
    logic [DW-1:0] dat_in;
    logic [1:0]    cke_in, odt_in;
    logic [DW-1:0] dat_a, dat_b;
    logic [1:0]    cs_n_a, cs_n_b, cke_a, cke_b, odt_a, odt_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cabuf_ca_register dut (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs_n_in(cs_n_in),
        .dat_in(dat_in), .cke_in(cke_in), .odt_in(odt_in),
        .dat_a(dat_a), .dat_b(dat_b), .cs_n_a(cs_n_a), .cs_n_b(cs_n_b),
        .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_copies();
        chk("R7 dat copy", {10'd0, dat_b}, {10'd0, dat_a});
        chk("R7 ctl copy", {26'd0, cs_n_b, cke_b, odt_b}, {26'd0, cs_n_a, cke_a, odt_a});
    endtask

    // Drive at falling edge, sample 5 ns after the following rising edge.
    task automatic step(input logic ge, input logic [1:0] cs, input logic [DW-1:0] d,
                        input logic [1:0] ck, input logic [1:0] od);
        @(negedge clk);
        gate_en = ge; cs_n_in = cs; dat_in = d; cke_in = ck; odt_in = od;
        @(posedge clk);
        #5;
    endtask

    task automatic t_reset_state();
        chk("R1 dat", {10'd0, dat_a}, 32'd0);
        chk("R1 ctl", {26'd0, cs_n_a, cke_a, odt_a}, 32'd0);
        step(1'b0, 2'b01, 22'h3ABCDE, 2'b11, 2'b11);
        step(1'b1, 2'b00, 22'h155555, 2'b10, 2'b01);
        chk("R9 dat", {10'd0, dat_a}, 32'd0);
        chk("R9 ctl", {26'd0, cs_n_b, cke_b, odt_b}, 32'd0);
    endtask

    task automatic t_release();
        @(negedge clk);
        gate_en = 1'b1; cs_n_in = 2'b11; dat_in = 22'h2F0F0F;
        cke_in = 2'b01; odt_in = 2'b10;
        rst_n = 1'b1;
        #2;
        chk("R8 before edge dat", {10'd0, dat_a}, 32'd0);
        chk("R8 before edge ctl", {26'd0, cs_n_a, cke_a, odt_a}, 32'd0);
        @(posedge clk); #5;
        chk("R8 blocked edge dat", {10'd0, dat_a}, 32'd0);
        chk("R6 cs after release", {30'd0, cs_n_a}, 32'd3);
        chk("R5 cke after release", {30'd0, cke_a}, 32'd1);
        chk("R5 odt after release", {30'd0, odt_b}, 32'd2);
        chk_copies();
    endtask

    task automatic t_open_mode();
        step(1'b0, 2'b11, 22'h123456, 2'b10, 2'b00);
        chk("R2 cs high", {10'd0, dat_a}, {10'd0, 22'h123456});
        step(1'b0, 2'b00, 22'h0A5A5A, 2'b01, 2'b11);
        chk("R2 cs low", {10'd0, dat_b}, {10'd0, 22'h0A5A5A});
        step(1'b0, 2'b11, 22'h3FFFFF, 2'b00, 2'b01);
        chk("R2 all ones", {10'd0, dat_a}, {10'd0, 22'h3FFFFF});
        chk_copies();
    endtask

    task automatic t_selected();
        step(1'b1, 2'b10, 22'h111111, 2'b11, 2'b00);
        chk("R3 cs0 low", {10'd0, dat_a}, {10'd0, 22'h111111});
        chk("R6 cs 10", {30'd0, cs_n_a}, 32'd2);
        step(1'b1, 2'b01, 22'h222222, 2'b11, 2'b00);
        chk("R3 cs1 low", {10'd0, dat_a}, {10'd0, 22'h222222});
        chk("R6 cs 01", {30'd0, cs_n_b}, 32'd1);
        step(1'b1, 2'b00, 22'h033333, 2'b11, 2'b00);
        chk("R3 both low", {10'd0, dat_b}, {10'd0, 22'h033333});
        chk_copies();
    endtask

    task automatic t_blocked();
        step(1'b1, 2'b11, 22'h2AAAAA, 2'b01, 2'b10);
        chk("R4 hold 1", {10'd0, dat_a}, {10'd0, 22'h033333});
        chk("R5 cke while blocked", {30'd0, cke_a}, 32'd1);
        chk("R5 odt while blocked", {30'd0, odt_a}, 32'd2);
        chk("R6 cs while blocked", {30'd0, cs_n_a}, 32'd3);
        step(1'b1, 2'b11, 22'h000001, 2'b10, 2'b01);
        chk("R4 hold 2", {10'd0, dat_b}, {10'd0, 22'h033333});
        chk("R5 cke 2", {30'd0, cke_b}, 32'd2);
        chk_copies();
        step(1'b1, 2'b01, 22'h000001, 2'b10, 2'b01);
        chk("R3 reopen", {10'd0, dat_a}, {10'd0, 22'h000001});
    endtask

    task automatic t_async_reset();
        step(1'b0, 2'b00, 22'h3C3C3C, 2'b11, 2'b11);
        chk("R2 before reset", {10'd0, dat_a}, {10'd0, 22'h3C3C3C});
        #3;
        rst_n = 1'b0;
        #1;
        chk("R1 async dat", {10'd0, dat_a}, 32'd0);
        chk("R1 async ctl", {26'd0, cs_n_a, cke_a, odt_a}, 32'd0);
        step(1'b0, 2'b00, 22'h3C3C3C, 2'b11, 2'b11);
        chk("R9 edge in reset", {10'd0, dat_b}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; gate_en = 1'b0; cs_n_in = 2'b11;
        dat_in = '0; cke_in = '0; odt_in = '0;
        #5;
        t_reset_state();
        t_release();
        t_open_mode();
        t_selected();
        t_blocked();
        t_async_reset();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule